// File: doc/BRIEF.md
# Dual-Output Sawtooth PWM Timer Channel

This block is a single timer channel in which one up-counter, advanced by a power-of-four clock prescaler, runs as a sawtooth from zero to a programmable period value and then wraps to zero. Two outputs, A and B, share this counter and the period. Each has its own compare value, enable bit and output-mode code. In the supported mode code, an output goes high at the start of every cycle and falls when the count reaches its compare value. The high time therefore equals the compare value in count ticks.

Software drives the channel through a word-addressed register port: a control word, a count-direction word, an output-control word, a buffer-enable word, the counter itself, two compare words and the period word. All writes take effect at once. The usual sequence is: stop the counter, pick the prescale, load the period and compare values, zero the counter, enable the outputs and set the run bit. The prescale and mode fields are locked while the counter runs. When counting stops, both outputs fall to low.

Top module: `saw_pwm_channel`

## Requirements
- R1: After reset every register reads 0 and both outputs are low.
- R2: Register byte offsets are 0x2C control, 0x30 direction, 0x34 output control, 0x40 buffer enable, 0x48 counter, 0x4C compare A, 0x50 compare B and 0x64 period; the low two address bits are ignored. Control holds the run bit at bit 0, the mode at [18:16] and the prescale at [26:24]. Direction holds bits [1:0]. Output control holds the A code at [4:0], the A enable at bit 8, the B code at [20:16] and the B enable at bit 24. Unused bits and unmapped offsets read 0.
- R3: While running, the counter advances once every 4^P clocks, where P is the prescale and values above 5 act as 5. The first advance comes 4^P clocks after the edge that sets the run bit.
- R4: In mode 0 the counter runs 0,1,...,period and then returns to 0. A value at or above the period wraps to 0 on the next advance. In any other mode the counter does not advance.
- R5: While the run bit is 0 the counter holds its value.
- R6: A control write made while the run bit is 1 updates only the run bit; the mode and prescale fields keep their values.
- R7: A write to the counter loads it at that clock edge and overrides any advance at that edge.
- R8: With output code 0x1B, the output enabled, the run bit set and mode 0, the output is high while count < compare. This gives compare ticks high in each cycle of period+1 ticks. The output follows the counter one clock later.
- R9: A compare value at or above the period holds the output high for the whole cycle; a compare value of 0 holds it low.
- R10: An output is low one clock after the run bit is 0, the output is disabled, its code differs from 0x1B, or the mode is nonzero.
- R11: Outputs A and B share the counter and period but follow their own compare value and enable bit independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |

## Verification
A register write lands at the clock edge where the strobe is sampled, and a readback is valid at the next falling edge. The counter's first advance comes 4^P edges after the run bit is written, and each output trails the counter by one more edge. The bench drives at falling edges and samples there. For first-advance timing it counts edges exactly, checking the edge before and the edge of the advance. It checks a stop or disable two edges later. It measures duty and edge counts over windows that are whole multiples of the period, so the result does not depend on where the window starts.

// File: rtl/saw_pwm_pkg.sv
package saw_pwm_pkg;
   localparam int DATA_W = 32;

   // byte offsets; decode uses the word index
   localparam logic [7:0] OFF_CTL  = 8'h2C;
   localparam logic [7:0] OFF_DIR  = 8'h30;
   localparam logic [7:0] OFF_OCTL = 8'h34;
   localparam logic [7:0] OFF_BUF  = 8'h40;
   localparam logic [7:0] OFF_CNT  = 8'h48;
   localparam logic [7:0] OFF_CMPA = 8'h4C;
   localparam logic [7:0] OFF_CMPB = 8'h50;
   localparam logic [7:0] OFF_PER  = 8'h64;

   localparam int CODE_W = 5;
   localparam logic [CODE_W-1:0] CODE_HI_CYCLE_TOGGLE = 5'h1B;

   typedef enum logic [2:0] {
      MODE_SAW = 3'd0
   } run_mode_e;
endpackage

// File: rtl/spc_prescaler.sv
module spc_prescaler #(
   parameter int PSC_W   = 3,
   parameter int PSC_MAX = 5,
   localparam int DIV_W  = 2 * PSC_MAX
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PSC_W-1:0] psc,
   output logic             tick
);
   logic [PSC_W-1:0] psc_eff;
   logic [DIV_W-1:0] lim;
   logic [DIV_W-1:0] div_q;

   always_comb begin
      psc_eff = (psc > PSC_W'(PSC_MAX)) ? PSC_W'(PSC_MAX) : psc;
      lim     = DIV_W'((32'd1 << (32'(psc_eff) * 2)) - 32'd1);
   end

   assign tick = run && (div_q == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                div_q <= '0;
      else if (!run || tick)     div_q <= '0;
      else                       div_q <= div_q + DIV_W'(1);
   end
endmodule

// File: rtl/spc_counter.sv
module spc_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             saw_mode,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] per,
   output logic [CNT_W-1:0] cnt
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (load)                 cnt_q <= load_val;
      else if (tick && saw_mode) begin
         if (cnt_q >= per)           cnt_q <= '0;
         else                        cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign cnt = cnt_q;
endmodule

// File: rtl/spc_output.sv
module spc_output
   import saw_pwm_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              en,
   input  logic [CODE_W-1:0] code,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [CNT_W-1:0]  cmp,
   input  logic [CNT_W-1:0]  per,
   output logic              pwm
);
   logic level;
   logic drive;

   // high from cycle start until the compare point; pinned high if compare covers the cycle
   assign level = (cmp >= per) ? (cmp != '0) : (cnt < cmp);
   assign drive = active && en && (code == CODE_HI_CYCLE_TOGGLE) && level;

   if (OUT_REG) begin : g_reg
      logic pwm_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pwm_q <= 1'b0;
         else        pwm_q <= drive;
      end
      assign pwm = pwm_q;
   end else begin : g_comb
      assign pwm = drive;
   end
endmodule

// File: rtl/saw_pwm_channel.sv
module saw_pwm_channel
   import saw_pwm_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter int PSC_W   = 3,
   parameter int PSC_MAX = 5,
   parameter int ADDR_W  = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              pwm_a,
   output logic              pwm_b
);
   localparam int NUM_OUT = 2;
   localparam int IDX_W   = ADDR_W - 2;

   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("CNT_W must lie in 2..32");
   end
   if (PSC_W != 3) begin : g_bad_psc_w
      $error("PSC_W must be 3 to match the control field");
   end
   if (PSC_MAX < 1 || PSC_MAX > 7) begin : g_bad_psc_max
      $error("PSC_MAX must lie in 1..7");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must cover offset 0x64");
   end

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
      return a[ADDR_W-1:2] == IDX_W'(off[7:2]);
   endfunction

   logic               start_q;
   logic [2:0]         mode_q;
   logic [PSC_W-1:0]   psc_q;
   logic [1:0]         dir_q;
   logic [31:0]        buf_q;
   logic [CNT_W-1:0]   per_q;
   logic [CNT_W-1:0]   cmp_q  [NUM_OUT];
   logic [NUM_OUT-1:0] oen_q;
   logic [CODE_W-1:0]  code_q [NUM_OUT];

   logic               run_w;
   logic               tick_w;
   logic               cnt_wr;
   logic [CNT_W-1:0]   cnt_w;
   logic [CNT_W-1:0]   cnt_ld_val;
   logic               saw_w;
   logic [NUM_OUT-1:0] pwm_w;
   logic               unused_addr_lsb;

   assign unused_addr_lsb = ^reg_addr[1:0];
   assign run_w      = start_q;
   assign saw_w      = (mode_q == MODE_SAW);
   assign cnt_wr     = reg_wr && hit(reg_addr, OFF_CNT);
   assign cnt_ld_val = reg_wdata[CNT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         mode_q  <= '0;
         psc_q   <= '0;
         dir_q   <= '0;
         buf_q   <= '0;
         per_q   <= '0;
         oen_q   <= '0;
         for (int i = 0; i < NUM_OUT; i++) begin
            cmp_q[i]  <= '0;
            code_q[i] <= '0;
         end
      end else if (reg_wr) begin
         if (hit(reg_addr, OFF_CTL)) begin
            start_q <= reg_wdata[0];
            if (!start_q) begin
               mode_q <= reg_wdata[18:16];
               psc_q  <= reg_wdata[26:24];
            end
         end
         if (hit(reg_addr, OFF_DIR))  dir_q <= reg_wdata[1:0];
         if (hit(reg_addr, OFF_BUF))  buf_q <= reg_wdata;
         if (hit(reg_addr, OFF_PER))  per_q <= reg_wdata[CNT_W-1:0];
         if (hit(reg_addr, OFF_CMPA)) cmp_q[0] <= reg_wdata[CNT_W-1:0];
         if (hit(reg_addr, OFF_CMPB)) cmp_q[1] <= reg_wdata[CNT_W-1:0];
         if (hit(reg_addr, OFF_OCTL)) begin
            code_q[0] <= reg_wdata[4:0];
            oen_q[0]  <= reg_wdata[8];
            code_q[1] <= reg_wdata[20:16];
            oen_q[1]  <= reg_wdata[24];
         end
      end
   end

   spc_prescaler #(.PSC_W(PSC_W), .PSC_MAX(PSC_MAX)) psc_i (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run_w),
      .psc  (psc_q),
      .tick (tick_w)
   );

   spc_counter #(.CNT_W(CNT_W)) cnt_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_w),
      .saw_mode(saw_w),
      .load    (cnt_wr),
      .load_val(cnt_ld_val),
      .per     (per_q),
      .cnt     (cnt_w)
   );

   for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
      spc_output #(.CNT_W(CNT_W), .OUT_REG(OUT_REG)) out_i (
         .clk   (clk),
         .rst_n (rst_n),
         .active(run_w && saw_w),
         .en    (oen_q[g]),
         .code  (code_q[g]),
         .cnt   (cnt_w),
         .cmp   (cmp_q[g]),
         .per   (per_q),
         .pwm   (pwm_w[g])
      );
   end

   assign pwm_a = pwm_w[0];
   assign pwm_b = pwm_w[1];

   always_comb begin
      reg_rdata = '0;
      if (hit(reg_addr, OFF_CTL))
         reg_rdata = {5'b0, psc_q, 5'b0, mode_q, 15'b0, start_q};
      else if (hit(reg_addr, OFF_DIR))
         reg_rdata = {30'b0, dir_q};
      else if (hit(reg_addr, OFF_OCTL))
         reg_rdata = {7'b0, oen_q[1], 3'b0, code_q[1], 7'b0, oen_q[0], 3'b0, code_q[0]};
      else if (hit(reg_addr, OFF_BUF))
         reg_rdata = buf_q;
      else if (hit(reg_addr, OFF_CNT))
         reg_rdata = DATA_W'(cnt_w);
      else if (hit(reg_addr, OFF_CMPA))
         reg_rdata = DATA_W'(cmp_q[0]);
      else if (hit(reg_addr, OFF_CMPB))
         reg_rdata = DATA_W'(cmp_q[1]);
      else if (hit(reg_addr, OFF_PER))
         reg_rdata = DATA_W'(per_q);
   end
endmodule

// File: rtl/saw_pwm_channel_chk.sv
module saw_pwm_channel_chk #(
   parameter int CNT_W   = 32,
   parameter int PSC_W   = 3,
   parameter bit OUT_REG = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_w,
   input logic             tick_w,
   input logic             cnt_wr,
   input logic [CNT_W-1:0] cnt_w,
   input logic [CNT_W-1:0] cnt_ld_val,
   input logic [CNT_W-1:0] per_q,
   input logic [2:0]       mode_q,
   input logic [PSC_W-1:0] psc_q,
   input logic             pwm_a,
   input logic             pwm_b
);
   if (OUT_REG) begin : g_reg_chk
      AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         !run_w |=> (!pwm_a && !pwm_b));  // R10
   end else begin : g_comb_chk
      AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         !run_w |-> (!pwm_a && !pwm_b));  // R10
   end

   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_w && mode_q == 3'd0 && !cnt_wr && cnt_w >= per_q) |=> (cnt_w == '0));  // R4

   AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != 3'd0 && !cnt_wr) |=> $stable(cnt_w));  // R4

   AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_w && !cnt_wr) |=> $stable(cnt_w));  // R5

   AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      run_w |=> ($stable(psc_q) && $stable(mode_q)));  // R6

   AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (cnt_w == $past(cnt_ld_val)));  // R7
endmodule

bind saw_pwm_channel saw_pwm_channel_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W), .OUT_REG(OUT_REG)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .run_w     (run_w),
   .tick_w    (tick_w),
   .cnt_wr    (cnt_wr),
   .cnt_w     (cnt_w),
   .cnt_ld_val(cnt_ld_val),
   .per_q     (per_q),
   .mode_q    (mode_q),
   .psc_q     (psc_q),
   .pwm_a     (pwm_a),
   .pwm_b     (pwm_b)
);

// File: tb/saw_pwm_channel_tb_top.sv
`timescale 1ns/1ps
module saw_pwm_channel_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        pwm_a, pwm_b;

   int n_checks = 0;
   int n_err = 0;

   always #10 clk = ~clk;  // 50 MHz

   saw_pwm_channel dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_a(pwm_a), .pwm_b(pwm_b)
   );

   localparam logic [7:0] A_CTL = 8'h2C, A_DIR = 8'h30, A_OCTL = 8'h34, A_BUF = 8'h40,
                          A_CNT = 8'h48, A_CMPA = 8'h4C, A_CMPB = 8'h50, A_PER = 8'h64;
   localparam logic [31:0] IO_A = 32'h0000_011B, IO_B = 32'h011B_0000;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic cfg(input logic [2:0] psc, input logic [31:0] per, input logic [31:0] ca,
                      input logic [31:0] cb, input logic [31:0] io);
      wr(A_CTL, 32'h0);
      wr(A_CTL, {5'b0, psc, 24'h0});
      wr(A_PER, per);
      wr(A_CMPA, ca);
      wr(A_CMPB, cb);
      wr(A_OCTL, io);
      wr(A_DIR, 32'h3);
      wr(A_CNT, 32'h0);
      wr(A_CTL, {5'b0, psc, 23'h0, 1'b1});
   endtask

   task automatic measure(input int n, output int hi_a, output int hi_b, output int rise_a);
      logic prev;
      hi_a = 0; hi_b = 0; rise_a = 0;
      @(negedge clk);
      prev = pwm_a;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (pwm_a) hi_a++;
         if (pwm_b) hi_b++;
         if (pwm_a && !prev) rise_a++;
         prev = pwm_a;
      end
   endtask

   task automatic t_reset();
      logic [31:0] v;
      logic [7:0] addrs [8] = '{A_CTL, A_DIR, A_OCTL, A_BUF, A_CNT, A_CMPA, A_CMPB, A_PER};
      for (int i = 0; i < 8; i++) begin
         rd(addrs[i], v);
         check("R1 reg zero after reset", v, 32'h0);
      end
      check("R1 pwm_a low", {31'b0, pwm_a}, 32'h0);
      check("R1 pwm_b low", {31'b0, pwm_b}, 32'h0);
   endtask

   task automatic t_regmap();
      logic [31:0] v;
      wr(A_CTL, 32'hFFFF_FFFE);
      rd(A_CTL, v);  check("R2 control fields", v, 32'h0707_0000);
      wr(A_CTL, 32'h0);
      wr(A_DIR, 32'hFFFF_FFFF);
      rd(A_DIR, v);  check("R2 direction field", v, 32'h3);
      wr(A_OCTL, 32'hFFFF_FFFF);
      rd(A_OCTL, v); check("R2 output control fields", v, 32'h011F_011F);
      wr(A_BUF, 32'h0);
      rd(A_BUF, v);  check("R2 buffer enable", v, 32'h0);
      wr(A_PER, 32'h1234_5678);
      rd(A_PER, v);  check("R2 period", v, 32'h1234_5678);
      wr(A_CMPB, 32'h55);
      rd(A_CMPB + 8'h2, v); check("R2 low address bits ignored", v, 32'h55);
      rd(8'h00, v);  check("R2 unmapped reads zero", v, 32'h0);
   endtask

   task automatic t_first_tick();
      logic [31:0] v;
      cfg(3'd1, 32'd9, 32'd4, 32'd7, IO_A | IO_B);
      repeat (3) @(negedge clk);
      rd(A_CNT, v); check("R3 no advance before 4 clocks", v, 32'h0);
      @(negedge clk);
      rd(A_CNT, v); check("R3 first advance after 4 clocks", v, 32'h1);
   endtask

   task automatic t_duty();
      int ha, hb, ra;
      cfg(3'd1, 32'd9, 32'd4, 32'd7, IO_A | IO_B);
      repeat (50) @(negedge clk);
      measure(80, ha, hb, ra);
      check("R8 duty A prescale 4", ha, 32);
      check("R11 duty B prescale 4", hb, 56);
      check("R3 period with prescale 4", ra, 2);
      cfg(3'd0, 32'd4, 32'd2, 32'd3, IO_A | IO_B);
      repeat (12) @(negedge clk);
      measure(25, ha, hb, ra);
      check("R8 duty A no prescale", ha, 10);
      check("R11 duty B no prescale", hb, 15);
      check("R4 cycles of period+1 ticks", ra, 5);
   endtask

   task automatic t_wrap();
      logic [31:0] v, mx;
      int zeros;
      cfg(3'd0, 32'd9, 32'd4, 32'd7, IO_A);
      mx = 0; zeros = 0;
      for (int i = 0; i < 25; i++) begin
         @(negedge clk);
         rd(A_CNT, v);
         if (v > mx) mx = v;
         if (v == 0) zeros++;
      end
      check("R4 counter peaks at period", mx, 32'd9);
      check("R4 counter wraps to zero", zeros, 2);
      wr(A_PER, 32'd3);
      @(negedge clk);
      rd(A_CNT, v);
      check("R4 above-period value wraps", (v <= 3) ? 32'h1 : 32'h0, 32'h1);
   endtask

   task automatic t_edges();
      int ha, hb, ra;
      cfg(3'd0, 32'd9, 32'd9, 32'd0, IO_A | IO_B);
      repeat (12) @(negedge clk);
      measure(20, ha, hb, ra);
      check("R9 compare equal period stays high", ha, 20);
      check("R9 compare zero stays low", hb, 0);
      wr(A_CMPA, 32'd25);
      repeat (3) @(negedge clk);
      measure(20, ha, hb, ra);
      check("R9 compare above period stays high", ha, 20);
   endtask

   task automatic t_stop_lock();
      logic [31:0] v, v2;
      int ha, hb, ra;
      cfg(3'd0, 32'd9, 32'd4, 32'd7, IO_A | IO_B);
      repeat (15) @(negedge clk);
      wr(A_CTL, 32'h0302_0001);
      rd(A_CTL, v); check("R6 config locked while running", v, 32'h1);
      measure(30, ha, hb, ra);
      check("R6 duty unchanged after locked write", ha, 12);
      wr(A_CTL, 32'h0);
      @(negedge clk);
      check("R10 A low when stopped", {31'b0, pwm_a}, 32'h0);
      check("R10 B low when stopped", {31'b0, pwm_b}, 32'h0);
      rd(A_CNT, v);
      repeat (6) @(negedge clk);
      rd(A_CNT, v2);
      check("R5 counter holds when stopped", v2, v);
   endtask

   task automatic t_load();
      logic [31:0] v;
      wr(A_CNT, 32'd7);
      rd(A_CNT, v); check("R7 load while stopped", v, 32'd7);
      wr(A_CTL, 32'h1);
      repeat (5) @(negedge clk);
      wr(A_CNT, 32'd5);
      rd(A_CNT, v); check("R7 load overrides advance", v, 32'd5);
   endtask

   task automatic t_disable_code();
      int ha, hb, ra;
      cfg(3'd0, 32'd9, 32'd4, 32'd7, IO_A | IO_B);
      repeat (12) @(negedge clk);
      wr(A_OCTL, IO_B);
      @(negedge clk);
      measure(20, ha, hb, ra);
      check("R10 disabled A low", ha, 0);
      check("R11 B unaffected by A disable", hb, 14);
      wr(A_OCTL, 32'h011B_011A);
      @(negedge clk);
      measure(20, ha, hb, ra);
      check("R10 other code keeps A low", ha, 0);
   endtask

   task automatic t_mode();
      logic [31:0] v;
      int ha, hb, ra;
      cfg(3'd0, 32'd9, 32'd4, 32'd7, IO_A | IO_B);
      wr(A_CTL, 32'h0);
      wr(A_CTL, 32'h0001_0000);
      wr(A_CNT, 32'h0);
      wr(A_CTL, 32'h0001_0001);
      measure(20, ha, hb, ra);
      rd(A_CNT, v);
      check("R4 nonzero mode does not count", v, 32'h0);
      check("R10 nonzero mode keeps A low", ha, 0);
   endtask

   task automatic t_clamp();
      logic [31:0] v;
      cfg(3'd7, 32'd9, 32'd4, 32'd7, IO_A);
      rd(A_CTL, v); check("R2 prescale stored as written", v, 32'h0700_0001);
      repeat (1023) @(negedge clk);
      rd(A_CNT, v); check("R3 prescale 7 acts as 5 before", v, 32'h0);
      @(negedge clk);
      rd(A_CNT, v); check("R3 prescale 7 acts as 5 at 1024", v, 32'h1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_checks++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regmap();
      t_first_tick();
      t_duty();
      t_wrap();
      t_edges();
      t_stop_lock();
      t_load();
      t_disable_code();
      t_mode();
      t_clamp();
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
   end
endmodule